// File: doc/BRIEF.md
# Add-Subtract Digital Bit Synchronizer

This block recovers a receive bit clock from a synchronous serial data stream. It needs no oscillator of its own. It runs from a fixed reference clock at 128 times the baud rate. A seven-stage binary countdown, held as a 7-bit count, divides the reference down to one cycle per bit time. The top bit of that count is the recovered bit clock.

Every change of the received data level is compared with the phase of the count at that moment. When the bit boundary has not yet been reached (the clock lags the data), one extra reference pulse is added to the first divide-by-two stage. When the boundary has already passed (the clock leads the data), one pulse is swallowed. Each data transition therefore moves the recovered clock by exactly one reference period. The loop settles with data transitions at the count's wrap from its highest value to zero, which is where the bit clock falls. The rising edge of the bit clock then lies in the middle of each bit, ready for sampling.

The single-cycle advance and retard strobes are brought out for debug and monitoring.

Top module: `addsub_bitsync`

## Requirements
- R1: While rst_n is low, the count is zero and bit_clk, adv_stb and ret_stb are all low.
- R2: With en high and no data transitions, bit_clk is the top bit of a 7-bit count that rises by one on every reference clock edge. Its falling edges are therefore 128 cycles apart, and it is high for 64 of those cycles.
- R3: If rx_data changes level after clock edge k, let C be the count value just after edge k+1. If C is 64 to 127, adv_stb is high for exactly the one cycle after edge k+2. If C is 0 to 63, ret_stb is high for that cycle instead.
- R4: On the clock edge after an advance strobe, the count rises by two instead of one. The next falling edge of bit_clk therefore comes 127 cycles after the previous one instead of 128.
- R5: On the clock edge after a retard strobe, the count holds its value. The next falling edge of bit_clk therefore comes 129 cycles after the previous one.
- R6: Each data transition produces exactly one strobe. The two strobes are never high together, and neither strobe is raised when there is no transition.
- R7: On a clock edge where en is low, the count holds and both strobes are cleared. A transition detected in that cycle is dropped. Each such cycle delays the next falling edge of bit_clk by one cycle.
- R8: Data toggles every bit, with bit periods of 128 cycles except every fourth bit, which is 129 (or 127) cycles. From any starting phase, after 100 bits each falling edge of bit_clk lies between one cycle before and two cycles after edge k+1, where k is the edge after which the data changed. That means the count is within one of its wrap point when the transition is judged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock at 128 times the baud rate |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Count and correction enable; while low, the divider holds |
| rx_data | input | 1 | Received serial data, synchronous to clk |
| bit_clk | output | 1 | Recovered bit clock (top bit of the divider) |
| adv_stb | output | 1 | One-cycle strobe marking an added reference pulse |
| ret_stb | output | 1 | One-cycle strobe marking a swallowed reference pulse |

## Verification
A data change driven after edge k reaches the two-stage input register at edge k+1, raises a strobe at edge k+2, and alters the count at edge k+3. The bench learns the count's phase at the ports by timing bit_clk falling edges. It places each transition at a chosen count value, reads the strobe on the falling clock edge after k+2, and predicts the next bit_clk fall arithmetically from the last one: 128 cycles, plus or minus one for the correction, skipping any fall at or before edge k+3. Convergence is judged by comparing each of the last thirty bit_clk falls with edge k+1 of its own data transition.

// File: rtl/addsub_bitsync.sv
module addsub_bitsync #(
  parameter int STAGES = 7
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic rx_data,
  output logic bit_clk,
  output logic adv_stb,
  output logic ret_stb
);
  localparam int MSB = STAGES - 1;

  logic [STAGES-1:0] cnt;
  logic [1:0]        smp;
  logic              xing;
  logic              adv_q, ret_q;
  logic [STAGES-1:0] step;

  assign xing    = smp[0] ^ smp[1];
  assign bit_clk = cnt[MSB];
  assign adv_stb = adv_q;
  assign ret_stb = ret_q;

  always_ff @(posedge clk) begin
    if (!rst_n) smp <= '0;
    else        smp <= {smp[0], rx_data};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      adv_q <= 1'b0;
      ret_q <= 1'b0;
    end else begin
      adv_q <= en & xing &  cnt[MSB];
      ret_q <= en & xing & ~cnt[MSB];
    end
  end

  always_comb begin
    if (adv_q)      step = STAGES'(2);
    else if (ret_q) step = '0;
    else            step = STAGES'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)  cnt <= '0;
    else if (en) cnt <= cnt + step;
  end

  a_r1_reset_clear: assert property (@(posedge clk)
    !rst_n |=> (cnt == '0) && !adv_q && !ret_q);

  a_r2_free_run: assert property (@(posedge clk) disable iff (!rst_n)
    en && !adv_q && !ret_q |=> (cnt - $past(cnt)) == STAGES'(1));

  a_r4_add_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    en && adv_q |=> (cnt - $past(cnt)) == STAGES'(2));

  a_r5_swallow_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    en && ret_q |=> $stable(cnt));

  a_r6_needs_transition: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(adv_q) || $rose(ret_q) |-> $past(smp[0] != smp[1]));

  a_r7_hold_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(cnt) && !adv_q && !ret_q);
endmodule

// File: tb/addsub_bitsync_tb.sv
module addsub_bitsync_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0;
  logic rx_data = 1'b0;
  logic bit_clk, adv_stb, ret_stb;

  int cyc = 0;
  int last_fall = -1, last_rise = -1;
  int adv_cnt = 0, ret_cnt = 0;
  logic prev_bc = 1'b0;
  int checks = 0, failures = 0;
  bit done = 0;

  always #2 clk = ~clk;

  addsub_bitsync u_dut (
    .clk(clk), .rst_n(rst_n), .en(en), .rx_data(rx_data),
    .bit_clk(bit_clk), .adv_stb(adv_stb), .ret_stb(ret_stb)
  );

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (prev_bc && !bit_clk) last_fall = cyc;
    if (!prev_bc && bit_clk) last_rise = cyc;
    prev_bc = bit_clk;
    if (rst_n && adv_stb) adv_cnt++;
    if (rst_n && ret_stb) ret_cnt++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    #1;
  endtask

  task automatic wait_cyc(input int k);
    while (cyc < k) tick();
  endtask

  task automatic wait_fall(output int f);
    int lf;
    lf = last_fall;
    do tick(); while (last_fall == lf);
    f = last_fall;
  endtask

  // Place a transition so the count equals j just after edge k+1.
  task automatic corr(input int j, input bit exp_adv);
    int f, k, nom, a0, r0;
    wait_fall(f);
    k = f + j - 1;
    wait_cyc(k);
    a0 = adv_cnt; r0 = ret_cnt;
    rx_data = ~rx_data;
    wait_cyc(k + 2);
    if (exp_adv) chk(adv_stb === 1'b1 && ret_stb === 1'b0, "R3 advance strobe", adv_stb, 1);
    else         chk(ret_stb === 1'b1 && adv_stb === 1'b0, "R3 retard strobe", ret_stb, 1);
    nom = f + 128;
    while (nom <= k + 3) nom += 128;
    nom += exp_adv ? -1 : 1;
    while (last_fall <= k + 3) tick();
    chk(last_fall == nom, exp_adv ? "R4 shortened bit" : "R5 lengthened bit", last_fall - f, nom - f);
    chk((adv_cnt - a0) + (ret_cnt - r0) == 1, "R6 one strobe per transition",
        (adv_cnt - a0) + (ret_cnt - r0), 1);
  endtask

  task automatic conv(input int off, input int dir);
    int f, k, d, bad, worst;
    wait_fall(f);
    k = f + off;
    bad = 0; worst = 0;
    for (int i = 0; i < 130; i++) begin
      wait_cyc(k);
      rx_data = ~rx_data;
      wait_cyc(k + 5);
      if (i >= 100) begin
        d = last_fall - (k + 1);
        if (d < -1 || d > 2) begin
          bad++;
          worst = d;
        end
      end
      k += 128 + (((i % 4) == 3) ? dir : 0);
    end
    chk(bad == 0, "R8 lock window", worst, 0);
  endtask

  initial begin
    int f1, f2, f, a0, r0;
    repeat (4) tick();
    chk(bit_clk === 1'b0, "R1 bit_clk in reset", bit_clk, 0);
    chk(adv_stb === 1'b0, "R1 adv_stb in reset", adv_stb, 0);
    chk(ret_stb === 1'b0, "R1 ret_stb in reset", ret_stb, 0);
    rst_n = 1'b1;
    en = 1'b1;

    a0 = adv_cnt; r0 = ret_cnt;
    wait_fall(f1);
    wait_fall(f2);
    chk(f2 - f1 == 128, "R2 free-run period", f2 - f1, 128);
    chk(f2 - last_rise == 64, "R2 high time", f2 - last_rise, 64);
    chk(adv_cnt == a0 && ret_cnt == r0, "R6 no strobe without transition",
        (adv_cnt - a0) + (ret_cnt - r0), 0);

    corr(10, 1'b0);
    corr(63, 1'b0);
    corr(64, 1'b1);
    corr(100, 1'b1);
    corr(127, 1'b1);
    corr(128, 1'b0);

    wait_fall(f);
    wait_cyc(f + 20);
    a0 = adv_cnt; r0 = ret_cnt;
    en = 1'b0;
    wait_cyc(f + 22);
    rx_data = ~rx_data;
    wait_cyc(f + 30);
    en = 1'b1;
    wait_cyc(f + 34);
    chk(adv_cnt == a0 && ret_cnt == r0, "R7 transition dropped while off",
        (adv_cnt - a0) + (ret_cnt - r0), 0);
    while (last_fall <= f) tick();
    chk(last_fall - f == 138, "R7 hold delays fall", last_fall - f, 138);

    conv(5, 1);
    conv(40, 1);
    conv(70, 1);
    conv(110, 1);
    conv(5, -1);
    conv(40, -1);
    conv(70, -1);
    conv(110, -1);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule